// File: doc/BRIEF.md
# Multiplexed converter serial port

This block is the digital controller and four-wire serial port of a multiplexed delta-sigma converter. The analog modulator is replaced by a conversion timer whose length is set by `conv_len`. When the timer expires, the block captures a 32-bit result word from the parallel test input `result_in` and goes to sleep. It waits there until the host starts a read with a serial clock edge while chip select is low. During the read the block shifts the result out and, at the same time, collects a command word on the serial data input. That command word selects the channel, the reference and the speed for the conversion that follows.

All pins are sampled by the block's own clock `clk`. An edge on `sck` or `cs_n` is recognised at the first rising edge of `clk` that sees the new level. `sdo_oe` marks the clock cycles in which `sdo` would be driven; elsewhere the line is released. While no read is in progress, `sdo` doubles as a conversion-status line. A read can be cut short by raising chip select. The configuration is held in registers and changes only when a new conversion starts.

Top module: `adc_serial_ctrl`

## Requirements
- R1: `busy` is 1 for the whole of a conversion and 0 in sleep and during a read. A conversion lasts `conv_len` clock cycles, and 1 cycle when `conv_len` is 0.
- R2: `sdo_oe` is the inverse of `cs_n`. When `cs_n` is low, `sdo` is 1 during a conversion and 0 in sleep.
- R3: Sleep ends only on an `sck` rising edge seen while `cs_n` is low. `sck` edges while `cs_n` is high leave the block asleep.
- R4: `result_in` is captured when a conversion ends. During a read, `sdo` first shows bit 31 and moves to the next lower bit on each `sck` falling edge. The 32nd falling edge starts a new conversion.
- R5: A rising edge on `cs_n` during a read aborts the read and starts a new conversion in the same clock cycle.
- R6: `sdi` is sampled on every `sck` rising edge of a read, including the edge that ends sleep. The first 3 bits are a prefix. The next 5 bits are the channel field, received MSB first into `cfg_chan`: bit 4 is 1 for a single-ended input and 0 for a differential one, bit 3 is 1 for the shared global reference and 0 for the channel's own reference, and bits 2:0 pick the channel. The last 5 bits are the speed field, received MSB first into `cfg_speed`. With prefix 101, both fields take effect at the clock edge that starts the next conversion and not before.
- R7: The prefixes 000 and 100 leave `cfg_chan` and `cfg_speed` unchanged.
- R8: A speed field of 00000 keeps the previous `cfg_speed` while the channel field is still applied. As a result, `cfg_speed` is never zero.
- R9: Reset starts a conversion (`busy` = 1) with `cfg_chan` = 00000 (differential pair 0/1 on its own reference), `cfg_speed` = 00100 (bits 4:1 are the rate code, where 2 means oversampling by 256; bit 0 = 0 means 1x mode), and `cfg_bad` = 0.
- R10: An aborted read applies the command only if all 13 command bits had arrived before the abort.
- R11: Any prefix other than 101, 100 or 000 is handled like 000. It also sets `cfg_bad`, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial command input |
| conv_len | input | CNT_W (16) | Conversion time in clock cycles |
| result_in | input | WORD_W (32) | Result word captured at the end of a conversion |
| busy | output | 1 | High while a conversion runs |
| sdo | output | 1 | Serial data / conversion status |
| sdo_oe | output | 1 | High when `sdo` is driven |
| cfg_chan | output | FLD_W (5) | Applied channel/reference field |
| cfg_speed | output | FLD_W (5) | Applied speed/mode field |
| cfg_bad | output | 1 | Sticky flag set by an unknown prefix |

## Verification
Every pin change takes effect at the next rising edge of `clk`. `busy`, `sdo` and the configuration therefore change one clock after the bench drives `sck` or `cs_n`, and `busy` falls exactly `conv_len` clocks after a conversion starts. The bench drives pins on the falling edge of `clk`. A behavioural model advances on the same rising edge as the design, and the two are compared 1 ns after every rising edge, which catches any change that arrives a cycle early or late. The directed checks wait two clocks after each pin change before sampling, and they count the conversion length cycle by cycle from reset.

// File: rtl/adc_serial_ctrl.sv
module adc_serial_ctrl #(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 16,
  parameter int PFX_W  = 3,
  parameter int FLD_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              sdi,
  input  logic [CNT_W-1:0]  conv_len,
  input  logic [WORD_W-1:0] result_in,
  output logic              busy,
  output logic              sdo,
  output logic              sdo_oe,
  output logic [FLD_W-1:0]  cfg_chan,
  output logic [FLD_W-1:0]  cfg_speed,
  output logic              cfg_bad
);
  localparam int BODY_W = 2 * FLD_W;
  localparam int CMD_W  = PFX_W + BODY_W;
  localparam int BIT_W  = $clog2(WORD_W);
  localparam int IN_W   = $clog2(CMD_W + 1);
  localparam logic [CNT_W:0]   CONV_ONE  = (CNT_W + 1)'(1);
  localparam logic [FLD_W-1:0] SPEED_RST = FLD_W'(4);
  localparam logic [PFX_W-1:0] PFX_UPD   = PFX_W'(5);
  localparam logic [PFX_W-1:0] PFX_KEEP  = PFX_W'(4);
  localparam logic [PFX_W-1:0] PFX_NOP   = '0;
  localparam logic [1:0] ST_CONV = 2'd0, ST_SLEEP = 2'd1, ST_OUT = 2'd2;

  logic [1:0]        state;
  logic              sck_q, cs_q;
  logic [CNT_W-1:0]  conv_cnt;
  logic [BIT_W-1:0]  fall_cnt;
  logic [WORD_W-1:0] word_q;
  logic [IN_W-1:0]   in_cnt;
  logic [PFX_W-1:0]  pfx_q;
  logic [BODY_W-1:0] body_q;

  wire sck_rise  = sck & ~sck_q;
  wire sck_fall  = ~sck & sck_q;
  wire cs_rise   = cs_n & ~cs_q;
  wire in_out    = (state == ST_OUT);
  wire conv_last = ({1'b0, conv_cnt} + CONV_ONE) >= {1'b0, conv_len};
  wire wake      = (state == ST_SLEEP) & sck_rise & ~cs_n;
  wire frame_end = in_out & ~cs_n & sck_fall & (fall_cnt == BIT_W'(WORD_W - 1));
  wire start     = in_out & (cs_rise | frame_end);
  wire take_bit  = wake | (in_out & ~cs_n & sck_rise & (in_cnt < IN_W'(CMD_W)));
  wire to_pfx    = wake | (in_cnt < IN_W'(PFX_W));

  wire got_pfx   = in_cnt >= IN_W'(PFX_W);
  wire got_all   = in_cnt == IN_W'(CMD_W);
  wire pfx_known = (pfx_q == PFX_UPD) | (pfx_q == PFX_KEEP) | (pfx_q == PFX_NOP);
  wire [FLD_W-1:0] new_chan  = body_q[BODY_W-1 -: FLD_W];
  wire [FLD_W-1:0] new_speed = body_q[FLD_W-1:0];

  assign busy   = (state == ST_CONV);
  assign sdo_oe = ~cs_n;
  assign sdo    = sdo_oe & (busy | (in_out & word_q[WORD_W-1]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_CONV;
      sck_q     <= 1'b0;
      cs_q      <= 1'b1;
      conv_cnt  <= '0;
      fall_cnt  <= '0;
      word_q    <= '0;
      in_cnt    <= '0;
      pfx_q     <= '0;
      body_q    <= '0;
      cfg_chan  <= '0;
      cfg_speed <= SPEED_RST;
      cfg_bad   <= 1'b0;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;

      case (state)
        ST_CONV: begin
          if (conv_last) begin
            state  <= ST_SLEEP;
            word_q <= result_in;
          end else begin
            conv_cnt <= conv_cnt + CNT_W'(1);
          end
        end
        ST_SLEEP: begin
          if (wake) begin
            state    <= ST_OUT;
            fall_cnt <= '0;
          end
        end
        default: begin
          if (start) begin
            state    <= ST_CONV;
            conv_cnt <= '0;
          end else if (~cs_n & sck_fall) begin
            fall_cnt <= fall_cnt + BIT_W'(1);
            word_q   <= {word_q[WORD_W-2:0], 1'b0};
          end
        end
      endcase

      if (take_bit) begin
        in_cnt <= wake ? IN_W'(1) : in_cnt + IN_W'(1);
        if (to_pfx) pfx_q  <= {pfx_q[PFX_W-2:0], sdi};
        else        body_q <= {body_q[BODY_W-2:0], sdi};
      end

      if (start) begin
        if (got_all && pfx_q == PFX_UPD) begin
          cfg_chan <= new_chan;
          if (new_speed != '0) cfg_speed <= new_speed;
        end
        if (got_pfx && !pfx_known) cfg_bad <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_serial_ctrl_sva.sv
module adc_serial_ctrl_sva #(
  parameter int FLD_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             busy,
  input logic             sdo,
  input logic             sdo_oe,
  input logic [FLD_W-1:0] cfg_chan,
  input logic [FLD_W-1:0] cfg_speed,
  input logic             cfg_bad,
  input logic [1:0]       st
);
  localparam logic [1:0] ST_OUT = 2'd2;

  assert_eoc_during_conv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cs_n) |-> (sdo_oe && sdo));

  assert_cfg_only_at_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(busy) |-> ($stable(cfg_chan) && $stable(cfg_speed)));

  assert_speed_never_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_speed != '0);

  assert_bad_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_bad) |-> cfg_bad);

  assert_cs_abort_restarts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_OUT && $rose(cs_n)) |=> busy);
endmodule

bind adc_serial_ctrl adc_serial_ctrl_sva #(.FLD_W(FLD_W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .busy      (busy),
  .sdo       (sdo),
  .sdo_oe    (sdo_oe),
  .cfg_chan  (cfg_chan),
  .cfg_speed (cfg_speed),
  .cfg_bad   (cfg_bad),
  .st        (state)
);

// File: tb/tb_adc_serial_ctrl.sv
`timescale 1ns/1ps
module tb_adc_serial_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sck = 1'b0;
  logic        sdi = 1'b0;
  logic [15:0] conv_len = 16'd20;
  logic [31:0] result_in = 32'hA5C3_0F81;
  wire         busy, sdo, sdo_oe, cfg_bad;
  wire  [4:0]  cfg_chan, cfg_speed;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  adc_serial_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .conv_len(conv_len), .result_in(result_in),
    .busy(busy), .sdo(sdo), .sdo_oe(sdo_oe),
    .cfg_chan(cfg_chan), .cfg_speed(cfg_speed), .cfg_bad(cfg_bad)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference model: 0 converting, 1 asleep, 2 reading
  int          m_st, m_cnt, m_nf;
  logic [31:0] m_word;
  bit          m_bits[$];
  logic [4:0]  m_chan, m_spd;
  bit          m_bad;
  logic        m_psck, m_pcs;
  bit          m_rise, m_fall, m_csr;

  task automatic m_start();
    if (m_bits.size() >= 3) begin
      int p;
      p = 4 * m_bits[0] + 2 * m_bits[1] + m_bits[2];
      if (p == 5 && m_bits.size() == 13) begin
        logic [4:0] c, s;
        c = '0; s = '0;
        for (int j = 0; j < 5; j++) begin
          c = {c[3:0], m_bits[3 + j]};
          s = {s[3:0], m_bits[8 + j]};
        end
        m_chan = c;
        if (s != 5'd0) m_spd = s;
      end
      if (p != 0 && p != 4 && p != 5) m_bad = 1'b1;
    end
    m_st = 0;
    m_cnt = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_nf = 0;
      m_chan = 5'd0; m_spd = 5'b00100; m_bad = 1'b0;
      m_psck = 1'b0; m_pcs = 1'b1;
      m_bits.delete();
    end else begin
      m_rise = sck && !m_psck;
      m_fall = !sck && m_psck;
      m_csr  = cs_n && !m_pcs;
      case (m_st)
        0: if (m_cnt + 1 >= int'(conv_len)) begin m_st = 1; m_word = result_in; end
           else m_cnt++;
        1: if (m_rise && !cs_n) begin
             m_st = 2; m_nf = 0;
             m_bits.delete();
             m_bits.push_back(sdi);
           end
        default: begin
          if (m_csr) m_start();
          else if (!cs_n) begin
            if (m_rise && m_bits.size() < 13) m_bits.push_back(sdi);
            if (m_fall) begin
              if (m_nf == 31) m_start();
              else m_nf++;
            end
          end
        end
      endcase
      m_psck = sck;
      m_pcs = cs_n;
    end
  end

  // cycle-by-cycle comparison, 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      chk("R1 busy vs model", 32'(busy), 32'(m_st == 0));
      chk("R2 sdo_oe vs model", 32'(sdo_oe), 32'(!cs_n));
      if (!cs_n) begin
        if (m_st == 2) chk("R4 sdo data vs model", 32'(sdo), (m_word >> (31 - m_nf)) & 32'd1);
        else           chk("R2 sdo status vs model", 32'(sdo), 32'(m_st == 0));
      end
      chk("R6 cfg_chan vs model", 32'(cfg_chan), 32'(m_chan));
      chk("R8 cfg_speed vs model", 32'(cfg_speed), 32'(m_spd));
      chk("R11 cfg_bad vs model", 32'(cfg_bad), 32'(m_bad));
    end
  end

  task automatic wait_sleep();
    while (busy) @(negedge clk);
  endtask

  task automatic frame(input logic [12:0] cmd, input int nbits, output logic [31:0] got);
    logic [12:0] sh;
    sh = cmd;
    got = '0;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi = sh[12];
      sh = sh << 1;
      sck = 1'b1;
      repeat (2) @(negedge clk);
      got = {got[30:0], sdo};
      sck = 1'b0;
      repeat (2) @(negedge clk);
    end
    cs_n = 1'b1;
    sdi = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #1000000;
    n_chk++;
    n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] got;
    int cyc;
    repeat (4) @(negedge clk);
    chk("R9 reset busy", 32'(busy), 32'd1);
    chk("R9 reset cfg_chan", 32'(cfg_chan), 32'd0);
    chk("R9 reset cfg_speed", 32'(cfg_speed), 32'd4);
    chk("R9 reset cfg_bad", 32'(cfg_bad), 32'd0);
    rst_n = 1'b1;
    cs_n = 1'b0;
    @(negedge clk);
    cyc = 1;
    chk("R2 eoc high while converting", 32'(sdo & sdo_oe), 32'd1);
    while (busy) begin
      @(negedge clk);
      cyc++;
    end
    chk("R1 conversion length", 32'(cyc), 32'd20);
    chk("R2 eoc low in sleep", 32'(sdo), 32'd0);
    cs_n = 1'b1;
    @(negedge clk);
    chk("R2 released with cs high", 32'(sdo_oe), 32'd0);
    sck = 1'b1; repeat (2) @(negedge clk);
    sck = 1'b0; repeat (2) @(negedge clk);
    cs_n = 1'b0; repeat (2) @(negedge clk);
    chk("R3 sck with cs high keeps sleep", 32'(sdo), 32'd0);
    chk("R3 still idle", 32'(busy), 32'd0);
    cs_n = 1'b1; repeat (2) @(negedge clk);

    frame(13'b101_10110_01100, 32, got);
    chk("R4 result word", got, 32'hA5C3_0F81);
    chk("R4 conversion restarts", 32'(busy), 32'd1);
    chk("R6 channel applied", 32'(cfg_chan), 32'b10110);
    chk("R6 speed applied", 32'(cfg_speed), 32'b01100);
    result_in = 32'h5A3C_F07E;
    conv_len = 16'd3;

    wait_sleep();
    frame(13'b101_00011_00000, 32, got);
    chk("R4 second result word", got, 32'h5A3C_F07E);
    chk("R8 channel applied", 32'(cfg_chan), 32'b00011);
    chk("R8 speed kept", 32'(cfg_speed), 32'b01100);

    wait_sleep();
    frame(13'b100_11111_11111, 32, got);
    chk("R7 prefix 100 channel kept", 32'(cfg_chan), 32'b00011);
    chk("R7 prefix 100 speed kept", 32'(cfg_speed), 32'b01100);
    wait_sleep();
    frame(13'b000_10101_10101, 32, got);
    chk("R7 prefix 000 channel kept", 32'(cfg_chan), 32'b00011);
    chk("R7 prefix 000 speed kept", 32'(cfg_speed), 32'b01100);

    wait_sleep();
    frame(13'b101_11100_00001, 5, got);
    chk("R5 abort starts conversion", 32'(busy), 32'd1);
    chk("R10 partial command ignored", 32'(cfg_chan), 32'b00011);
    wait_sleep();
    frame(13'b101_01001_00111, 13, got);
    chk("R10 complete command on abort chan", 32'(cfg_chan), 32'b01001);
    chk("R10 complete command on abort speed", 32'(cfg_speed), 32'b00111);

    wait_sleep();
    frame(13'b110_11111_00011, 32, got);
    chk("R11 bad prefix flagged", 32'(cfg_bad), 32'd1);
    chk("R11 bad prefix keeps channel", 32'(cfg_chan), 32'b01001);
    conv_len = 16'd0;
    wait_sleep();
    frame(13'b101_10001_00010, 32, got);
    chk("R11 flag stays set", 32'(cfg_bad), 32'd1);
    chk("R6 channel after bad prefix", 32'(cfg_chan), 32'b10001);
    chk("R1 zero length conversion done", 32'(busy), 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule